// File: doc/BRIEF.md
# Rung-Driven Signed Up/Down Counter

This block is a counter that works the way a counter instruction in a programmable controller works. It holds a signed 16-bit running total and a 16-bit target. Two rung inputs drive it, one for counting up and one for counting down. Each input counts once on its false-to-true transition, however long it then stays true. The status outputs are two enable bits that follow the rung levels, a done bit and two sticky error flags. The done bit is set when the total has reached the target in signed terms. The error flags record wrap past the positive end and wrap past the negative end of the range.

A synchronous clear input returns the total and both error flags to zero and leaves the target alone. A one-word write port loads either the target or the total, so the controller that owns the block can set its starting point. The block is clocked by `clk_i` and has an asynchronous power-on reset `rst_ni`.

Top module: `rung_updown_counter`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `total_o` and `target_o` read 0, `wrap_hi_o`, `wrap_lo_o`, `up_en_o` and `dn_en_o` read 0, and `reached_o` reads 1.
- R2: A low-to-high change on `up_rung_i` adds one to `total_o` on the next rising clock edge. Keeping the input high adds nothing more, and a clock with no count, clear or total write leaves `total_o` unchanged.
- R3: A low-to-high change on `dn_rung_i` subtracts one from `total_o` on the next rising clock edge. Keeping the input high subtracts nothing more.
- R4: `up_en_o` and `dn_en_o` show the level that `up_rung_i` and `dn_rung_i` had at the previous rising clock edge. They do this whether or not a count happened.
- R5: An up count from 16'h7FFF (+32767) gives 16'h8000 (-32768) and sets `wrap_hi_o`. `wrap_hi_o` then stays at 1 until a clear or a power-on reset.
- R6: A down count from 16'h8000 (-32768) gives 16'h7FFF (+32767) and sets `wrap_lo_o`. `wrap_lo_o` then stays at 1 until a clear or a power-on reset.
- R7: `reached_o` is 1 exactly when `total_o` is greater than or equal to `target_o`, with both read as two's-complement signed values.
- R8: If both rung inputs rise in the same clock, `total_o`, `wrap_hi_o` and `wrap_lo_o` keep their values.
- R9: `clear_i` high at a rising edge sets `total_o` to 0 and clears both wrap flags, and it leaves `target_o` unchanged. A rung edge in that same clock is dropped. An input that stays high through the clear does not count again until it has gone low and then high.
- R10: With `wr_en_i` high, `wr_sel_i` = 0 loads `wr_data_i` into `target_o` and `wr_sel_i` = 1 loads it into `total_o`, from the next rising edge. A write to the total takes the place of any count in that clock and leaves the wrap flags unchanged. `clear_i` takes priority over a write to the total but does not block a write to the target.
- R11: A rung input that is already high when `rst_ni` is released does not count until it has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| clear_i | input | 1 | Synchronous clear of the total and the wrap flags |
| up_rung_i | input | 1 | Count-up rung level |
| dn_rung_i | input | 1 | Count-down rung level |
| wr_en_i | input | 1 | Write strobe for the load port |
| wr_sel_i | input | 1 | Write target: 0 loads the target, 1 loads the total |
| wr_data_i | input | 16 | Value to load |
| total_o | output | 16 | Signed running total |
| target_o | output | 16 | Signed target value |
| up_en_o | output | 1 | Registered level of the up rung |
| dn_en_o | output | 1 | Registered level of the down rung |
| reached_o | output | 1 | Total is at or above the target (signed) |
| wrap_hi_o | output | 1 | Sticky: total wrapped past +32767 |
| wrap_lo_o | output | 1 | Sticky: total wrapped past -32768 |

## Verification
A stuck or stale edge register in this block shows up one clock after the rung changes. It appears as a missing count, or as a second count while the input stays high, in `total_o`, and as an enable bit that does not follow the rung. A wrong wrap in the adder appears at the same edge as a total other than 16'h8000 or 16'h7FFF. Any lost sticky flag shows on a later clock that has no clear. Because `reached_o` is decoded directly from the two registers, a signed/unsigned mix-up there is visible the moment the total crosses zero against a negative target. The bench therefore compares every output after every clock against a model of its own.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;

  parameter int unsigned CNT_W = 16;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam cnt_t CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  // Increment with two's-complement wrap; bit CNT_W flags the wrap.
  function automatic logic [CNT_W:0] rcnt_inc(input cnt_t v);
    logic wrapped;
    wrapped = (v == CNT_MAX);
    return {wrapped, cnt_t'(v + cnt_t'(1))};
  endfunction

  // Decrement with two's-complement wrap; bit CNT_W flags the wrap.
  function automatic logic [CNT_W:0] rcnt_dec(input cnt_t v);
    logic wrapped;
    wrapped = (v == CNT_MIN);
    return {wrapped, cnt_t'(v - cnt_t'(1))};
  endfunction

  // Signed a >= b.
  function automatic logic rcnt_ge(input cnt_t a, input cnt_t b);
    return $signed(a) >= $signed(b);
  endfunction

endpackage

// File: rtl/rcnt_rung_edge.sv
module rcnt_rung_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rung_i,
  output logic level_o,
  output logic rise_o
);

  logic level_q;
  logic block_q;

  // block_q is set by power-on reset and held until the rung is seen low,
  // so an input already high at release never counts.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      block_q <= 1'b1;
    end else begin
      level_q <= rung_i;
      block_q <= block_q & rung_i;
    end
  end

  assign rise_o  = rung_i & ~level_q & ~block_q;
  assign level_o = level_q;

endmodule

// File: rtl/rcnt_accum.sv
module rcnt_accum
  import rcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic load_i,
  input  cnt_t load_val_i,
  input  logic up_evt_i,
  input  logic dn_evt_i,
  output cnt_t total_o,
  output logic wrap_hi_o,
  output logic wrap_lo_o
);

  cnt_t             total_q;
  logic             wrap_hi_q;
  logic             wrap_lo_q;
  logic             step_up;
  logic             step_dn;
  logic [CNT_W:0]   inc_res;
  logic [CNT_W:0]   dec_res;

  assign step_up = up_evt_i & ~dn_evt_i;
  assign step_dn = dn_evt_i & ~up_evt_i;
  assign inc_res = rcnt_inc(total_q);
  assign dec_res = rcnt_dec(total_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q   <= '0;
      wrap_hi_q <= 1'b0;
      wrap_lo_q <= 1'b0;
    end else if (clear_i) begin
      total_q   <= '0;
      wrap_hi_q <= 1'b0;
      wrap_lo_q <= 1'b0;
    end else if (load_i) begin
      total_q <= load_val_i;
    end else if (step_up) begin
      total_q   <= inc_res[CNT_W-1:0];
      wrap_hi_q <= wrap_hi_q | inc_res[CNT_W];
    end else if (step_dn) begin
      total_q   <= dec_res[CNT_W-1:0];
      wrap_lo_q <= wrap_lo_q | dec_res[CNT_W];
    end
  end

  assign total_o   = total_q;
  assign wrap_hi_o = wrap_hi_q;
  assign wrap_lo_o = wrap_lo_q;

endmodule

// File: rtl/rcnt_target.sv
module rcnt_target
  import rcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cnt_t load_val_i,
  input  cnt_t total_i,
  output cnt_t target_o,
  output logic reached_o
);

  cnt_t target_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     target_q <= '0;
    else if (load_i) target_q <= load_val_i;
  end

  assign target_o  = target_q;
  assign reached_o = rcnt_ge(total_i, target_q);

endmodule

// File: rtl/rung_updown_counter.sv
module rung_updown_counter
  import rcnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             up_rung_i,
  input  logic             dn_rung_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] target_o,
  output logic             up_en_o,
  output logic             dn_en_o,
  output logic             reached_o,
  output logic             wrap_hi_o,
  output logic             wrap_lo_o
);

  localparam int unsigned N_RUNG = 2;

  logic [N_RUNG-1:0] rung_lvl_in;
  logic [N_RUNG-1:0] rung_lvl_q;
  logic [N_RUNG-1:0] rung_rise;
  logic              up_evt;
  logic              dn_evt;
  logic              wr_total;
  logic              wr_target;
  cnt_t              total_w;

  assign rung_lvl_in = {dn_rung_i, up_rung_i};

  for (genvar g = 0; g < N_RUNG; g++) begin : g_rung
    rcnt_rung_edge u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rung_i  (rung_lvl_in[g]),
      .level_o (rung_lvl_q[g]),
      .rise_o  (rung_rise[g])
    );
  end

  assign up_evt    = rung_rise[0];
  assign dn_evt    = rung_rise[1];
  assign wr_total  = wr_en_i &  wr_sel_i;
  assign wr_target = wr_en_i & ~wr_sel_i;

  rcnt_accum u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .load_i     (wr_total),
    .load_val_i (wr_data_i),
    .up_evt_i   (up_evt),
    .dn_evt_i   (dn_evt),
    .total_o    (total_w),
    .wrap_hi_o  (wrap_hi_o),
    .wrap_lo_o  (wrap_lo_o)
  );

  rcnt_target u_target (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_target),
    .load_val_i (wr_data_i),
    .total_i    (total_w),
    .target_o   (target_o),
    .reached_o  (reached_o)
  );

  assign total_o = total_w;
  assign up_en_o = rung_lvl_q[0];
  assign dn_en_o = rung_lvl_q[1];

endmodule

// File: rtl/rcnt_checker.sv
module rcnt_checker
  import rcnt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic wr_tot,
  input logic up_in,
  input logic dn_in,
  input logic up_evt,
  input logic dn_evt,
  input cnt_t acc,
  input cnt_t pre,
  input logic cu,
  input logic cd,
  input logic done,
  input logic ov,
  input logic un
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_tot && up_evt && !dn_evt && acc != CNT_MAX) |=> (acc == $past(acc) + cnt_t'(1))); // R2
  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_tot && !up_evt && !dn_evt) |=> $stable(acc)); // R2
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_tot && dn_evt && !up_evt && acc != CNT_MIN) |=> (acc == $past(acc) - cnt_t'(1))); // R3
  AST_UP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (cu == $past(up_in) && cd == $past(dn_in))); // R4
  AST_OV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_tot && up_evt && !dn_evt && acc == CNT_MAX) |=> (acc == CNT_MIN && ov)); // R5
  AST_OV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !clr) |=> ov); // R5
  AST_UN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_tot && dn_evt && !up_evt && acc == CNT_MIN) |=> (acc == CNT_MAX && un)); // R6
  AST_UN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (un && !clr) |=> un); // R6
  AST_DONE_AT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == pre) |-> done); // R7
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_tot && up_evt && dn_evt) |=> (acc == $past(acc) && ov == $past(ov) && un == $past(un))); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0 && !ov && !un)); // R9
  AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tot && !clr) |=> (ov == $past(ov) && un == $past(un))); // R10

endmodule

bind rung_updown_counter rcnt_checker u_chk (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .clr    (clear_i),
  .wr_tot (wr_total),
  .up_in  (up_rung_i),
  .dn_in  (dn_rung_i),
  .up_evt (up_evt),
  .dn_evt (dn_evt),
  .acc    (total_o),
  .pre    (target_o),
  .cu     (up_en_o),
  .cd     (dn_en_o),
  .done   (reached_o),
  .ov     (wrap_hi_o),
  .un     (wrap_lo_o)
);

// File: tb/rung_updown_counter_bench.sv
module rung_updown_counter_bench;

  localparam int HALF = 10;   // 50 MHz
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        up = 1'b0;
  logic        dn = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] total, target;
  logic        cu, cd, done, ov, un;

  always #HALF clk = ~clk;

  rung_updown_counter u_rung_updown_counter (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .up_rung_i(up), .dn_rung_i(dn),
    .wr_en_i(we), .wr_sel_i(sel), .wr_data_i(wdata),
    .total_o(total), .target_o(target), .up_en_o(cu), .dn_en_o(cd),
    .reached_o(done), .wrap_hi_o(ov), .wrap_lo_o(un)
  );

  typedef struct {
    int    acc;
    int    pre;
    bit    ov, un, done, cu, cd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  // bench model
  int m_acc, m_pre;
  bit m_ov, m_un, m_lu, m_ld, m_bu, m_bd;

  function automatic int s16(input logic [15:0] v);
    return (v >= 16'h8000) ? int'(v) - 65536 : int'(v);
  endfunction

  task automatic model_reset();
    m_acc = 0; m_pre = 0; m_ov = 0; m_un = 0;
    m_lu = 0; m_ld = 0; m_bu = 1; m_bd = 1;
  endtask

  task automatic step(input bit u, input bit d, input bit c, input bit w,
                      input bit s, input logic [15:0] v, input string tag);
    bit   ue, de;
    exp_t e;
    @(negedge clk);
    up = u; dn = d; clr = c; we = w; sel = s; wdata = v;
    ue = u && !m_lu && !m_bu;
    de = d && !m_ld && !m_bd;
    if (c) begin
      m_acc = 0; m_ov = 0; m_un = 0;
    end else if (w && s) begin
      m_acc = s16(v);
    end else if (ue && !de) begin
      if (m_acc == 32767) begin m_acc = -32768; m_ov = 1; end
      else m_acc = m_acc + 1;
    end else if (de && !ue) begin
      if (m_acc == -32768) begin m_acc = 32767; m_un = 1; end
      else m_acc = m_acc - 1;
    end
    if (w && !s) m_pre = s16(v);
    m_lu = u; m_ld = d;
    m_bu = m_bu & u; m_bd = m_bd & d;
    e.acc = m_acc; e.pre = m_pre; e.ov = m_ov; e.un = m_un;
    e.done = (m_acc >= m_pre); e.cu = u; e.cd = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input bit u, input bit d, input string tag);
    step(u, d, 1'b0, 1'b0, 1'b0, 16'h0000, tag);
  endtask

  task automatic wr(input bit s, input logic [15:0] v, input string tag);
    step(up, dn, 1'b0, 1'b1, s, v, tag);
  endtask

  task automatic check_direct(input string tag);
    checks++;
    if (total !== 16'h0 || target !== 16'h0 || ov !== 1'b0 || un !== 1'b0 ||
        cu !== 1'b0 || cd !== 1'b0 || done !== 1'b1) begin
      errors++;
      $display("FAIL %s: total=%h target=%h ov=%b un=%b cu=%b cd=%b done=%b expected 0 0 0 0 0 0 1",
               tag, total, target, ov, un, cu, cd, done);
    end
  endtask

  task automatic power_reset(input bit u, input bit d);
    @(posedge clk); #(HALF/2 + 1);      // let the monitor drain
    @(negedge clk);
    up = u; dn = d; clr = 0; we = 0;
    rst_n = 1'b0;
    #1 check_direct("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1 check_direct("R1 after release");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(HALF/2);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (s16(total) != e.acc || s16(target) != e.pre || ov !== e.ov ||
            un !== e.un || done !== e.done || cu !== e.cu || cd !== e.cd) begin
          errors++;
          $display("FAIL %s: acc=%0d pre=%0d ov=%b un=%b done=%b cu=%b cd=%b expected acc=%0d pre=%0d ov=%b un=%b done=%b cu=%b cd=%b",
                   e.tag, s16(total), s16(target), ov, un, done, cu, cd,
                   e.acc, e.pre, e.ov, e.un, e.done, e.cu, e.cd);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: done=0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    power_reset(1'b0, 1'b0);
    idle(0, 0, "R1 idle");
    idle(0, 0, "R1 idle");
    wr(1'b0, 16'd3, "R10 load target 3");
    idle(0, 0, "R7 below target");
    idle(1, 0, "R2 first up edge");
    idle(1, 0, "R2 held high no count");
    idle(1, 0, "R4 up level held");
    idle(0, 0, "R4 up level low");
    idle(1, 0, "R2 second edge");
    idle(0, 0, "R2 release");
    idle(1, 0, "R7 reach target");
    idle(0, 0, "R7 at target");
    idle(0, 1, "R3 down edge");
    idle(0, 1, "R3 held no count");
    idle(0, 0, "R4 dn level low");
    idle(1, 1, "R8 both rise");
    idle(0, 0, "R8 both low");
    idle(1, 0, "R8 up only after");
    idle(1, 1, "R8 dn only while up held");
    idle(0, 0, "R2 quiet");
    wr(1'b1, 16'h7FFE, "R10 load total 7FFE");
    idle(1, 0, "R5 to 7FFF");
    idle(0, 0, "R5 quiet");
    idle(1, 0, "R5 wrap to 8000");
    idle(0, 0, "R5 ov sticky");
    idle(1, 0, "R5 ov sticky after count");
    step(0, 0, 0, 1, 1, 16'h1234, "R10 total write");
    step(1, 0, 0, 0, 0, 16'h0, "R10 edge");
    step(0, 0, 0, 0, 0, 16'h0, "R10 low");
    step(1, 0, 0, 1, 1, 16'h0100, "R10 write beats up edge");
    idle(0, 0, "R10 quiet");
    wr(1'b0, 16'hFFFB, "R7 negative target -5");
    wr(1'b1, 16'hFFFA, "R7 total -6 below -5");
    idle(1, 0, "R7 total -5 reaches -5");
    idle(0, 0, "R7 quiet");
    wr(1'b1, 16'h8001, "R10 load total 8001");
    idle(0, 1, "R6 to 8000");
    idle(0, 0, "R6 quiet");
    idle(0, 1, "R6 wrap to 7FFF");
    idle(0, 0, "R6 un sticky");
    idle(0, 1, "R6 un sticky after count");
    idle(0, 0, "R6 quiet");
    step(1, 0, 1, 0, 0, 16'h0, "R9 clear drops up edge");
    idle(1, 0, "R9 held high after clear");
    idle(0, 0, "R9 low");
    idle(1, 0, "R9 count again");
    idle(0, 0, "R9 quiet");
    step(0, 0, 1, 1, 1, 16'h0055, "R9 clear beats total write");
    step(0, 0, 1, 1, 0, 16'h0007, "R10 target write during clear");
    idle(0, 0, "R9 quiet");
    power_reset(1'b1, 1'b1);
    idle(1, 1, "R11 high at release");
    idle(1, 1, "R11 still high no count");
    idle(0, 1, "R11 up low");
    idle(1, 1, "R11 up counts dn blocked");
    idle(0, 0, "R11 both low");
    idle(0, 1, "R11 dn counts");
    idle(0, 0, "R11 quiet");
    @(posedge clk); #(HALF/2 + 1);
    @(posedge clk); #(HALF/2 + 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule